// File: doc/BRIEF.md
# Doorbell Mailbox Channel Unit

The block carries doorbell flags from one agent to another. It holds a small, parameterized number of 32-bit flag words, one per channel. A sending agent reaches them through its own register frame. A receiving agent reaches the same words through a second frame. Each frame sits on a simple read/write bus addressed in 32-bit words, and each frame spans 1024 words (4 KB).

The sender may raise flag bits only after it has gained access through a request/ready handshake. The receiver reads the flags either raw or filtered by a per-channel mask, and lowers the flags it has serviced. A single receiver interrupt line stays high while any unmasked flag is pending. Both frames also report the number of implemented channels and a fixed architecture identifier.

Addresses are word indices. Channel n occupies words n*8 to n*8+7 in both frames. Frame-wide registers sit at word 0x3E0 (channel count), word 0x3E2 (sender access request), word 0x3E3 (sender access ready) and word 0x3F3 (architecture identifier). Read data is registered. It is valid after the clock edge that samples the read and holds until the next read on the same bus.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset every flag word is 0, every mask word is all ones, access request and access ready are 0, both read data outputs are 0 and `irq` is low.
- R2: A sender write to channel word offset 3 (set), made while access ready is 1, ORs the written value into that channel's flag word. Sender offset 0 reads the flag word.
- R3: A sender set write made while access ready is 0 leaves every flag word unchanged.
- R4: A receiver write to channel word offset 2 (clear) removes the written bits from the flag word. Writing all ones leaves the word 0. Receiver offset 0 reads the flag word.
- R5: When a sender set and a receiver clear reach the same channel in the same cycle, the set is applied first and the clear second, so bits present in both are 0 afterwards.
- R6: Receiver offset 5 ORs the written bits into the channel mask, and offset 6 removes the written bits from it. Offset 4 reads the mask. The mask changes only on these receiver writes.
- R7: Receiver offset 1 reads the flag word AND NOT the mask.
- R8: `irq` is 1 exactly when some implemented channel has a nonzero masked status. It follows the flag and mask registers in the same cycle they change.
- R9: Sender word 0x3E2 stores bit 0 of the written value as the access request and reads it back. Access ready (word 0x3E3, bit 0) equals the request as it stood two clock edges earlier.
- R10: Word 0x3E0 reads the number of implemented channels in both frames. Word 0x3F3 reads 0x10 plus the minor revision parameter in both frames (major revision 1 in bits 7:4, minor in bits 3:0).
- R11: Reserved offsets, unlisted frame words and windows of channels at or above the implemented count read 0, and writes to them change no state.
- R12: A read updates the read data one clock edge after it is sampled. Without a read, the read data holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_en | input | 1 | Sender bus access strobe |
| s_we | input | 1 | Sender bus write (1) or read (0) |
| s_addr | input | 10 | Sender frame word address |
| s_wdata | input | 32 | Sender write data |
| s_rdata | output | 32 | Sender read data, registered |
| r_en | input | 1 | Receiver bus access strobe |
| r_we | input | 1 | Receiver bus write (1) or read (0) |
| r_addr | input | 10 | Receiver frame word address |
| r_wdata | input | 32 | Receiver write data |
| r_rdata | output | 32 | Receiver read data, registered |
| irq | output | 1 | Receiver interrupt, unmasked flag pending |

## Verification
The two buses are independent, so a sender set and a receiver clear can reach the same flag word on the same edge. That overlap is exactly where the set-then-clear order matters. A directed step drives both buses at once on one channel with overlapping bit patterns. A long random phase then drives both buses every cycle with mixed sets, clears and mask writes on a few channels, so such overlaps happen often. Each outcome is judged by reading the word back through both frames and by watching `irq`, against a bench model that applies the set before the clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = 10;
  localparam int CH_LIMIT  = 124;
  localparam int CH_IDX_W  = 7;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] waddr_t;

  // word offsets inside one channel window
  localparam logic [2:0] SND_STAT  = 3'd0;
  localparam logic [2:0] SND_SET   = 3'd3;
  localparam logic [2:0] RCV_STAT  = 3'd0;
  localparam logic [2:0] RCV_MSTAT = 3'd1;
  localparam logic [2:0] RCV_CLR   = 3'd2;
  localparam logic [2:0] RCV_MASK  = 3'd4;
  localparam logic [2:0] RCV_MSET  = 3'd5;
  localparam logic [2:0] RCV_MCLR  = 3'd6;

  // frame-wide word addresses
  localparam waddr_t FRM_CFG  = 10'h3E0;
  localparam waddr_t FRM_REQ  = 10'h3E2;
  localparam waddr_t FRM_RDY  = 10'h3E3;
  localparam waddr_t FRM_ARCH = 10'h3F3;

  localparam logic [3:0] ARCH_MAJOR = 4'h1;

  function automatic word_t arch_word(input logic [3:0] minor);
    return {24'h0, ARCH_MAJOR, minor};
  endfunction
endpackage

// File: rtl/mbx_channel.sv
module mbx_channel
  import mbx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  set_en,
  input  word_t set_val,
  input  logic  clr_en,
  input  logic  mset_en,
  input  logic  mclr_en,
  input  word_t rcv_val,
  output word_t flag_q,
  output word_t mask_q
);
  word_t flag_d;
  word_t mask_d;
  logic  flag_ce;
  logic  mask_ce;

  // set lands first, clear is applied on top of it
  always_comb begin
    flag_d = flag_q;
    if (set_en) flag_d = flag_d | set_val;
    if (clr_en) flag_d = flag_d & ~rcv_val;
    flag_ce = set_en | clr_en;
  end

  always_comb begin
    mask_d = mask_q;
    if (mset_en) mask_d = mask_d | rcv_val;
    if (mclr_en) mask_d = mask_d & ~rcv_val;
    mask_ce = mset_en | mclr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      mask_q <= '1;
    end else begin
      if (flag_ce) flag_q <= flag_d;
      if (mask_ce) mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/mbx_access_hs.sv
module mbx_access_hs #(
  parameter int READY_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_wr,
  input  logic req_val,
  output logic req_q,
  output logic ready
);
  logic req_d;
  logic [READY_LAT-1:0] stage_q;
  logic [READY_LAT-1:0] stage_d;

  always_comb begin
    req_d = req_wr ? req_val : req_q;
  end

  generate
    if (READY_LAT == 1) begin : g_one
      always_comb stage_d = req_q;
    end else begin : g_many
      always_comb stage_d = {stage_q[READY_LAT-2:0], req_q};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      stage_q <= '0;
    end else begin
      if (req_wr) req_q <= req_d;
      stage_q <= stage_d;
    end
  end

  assign ready = stage_q[READY_LAT-1];
endmodule

// File: rtl/mbx_snd_port.sv
module mbx_snd_port
  import mbx_pkg::*;
#(
  parameter int         NUM_CH    = 4,
  parameter logic [3:0] ARCH_MIN  = 4'h1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   we,
  input  waddr_t                 addr,
  input  logic                   wbit0,
  input  logic [NUM_CH-1:0][WORD_W-1:0] flags,
  input  logic                   req_q,
  input  logic                   ready,
  output logic [NUM_CH-1:0]      set_en,
  output logic                   req_wr,
  output logic                   req_val,
  output word_t                  rdata
);
  logic [CH_IDX_W-1:0] ch_idx;
  logic [2:0]          woff;
  logic                win_hit;
  logic                wr_go;
  logic                rd_go;
  word_t               rd_d;

  assign ch_idx  = addr[ADDR_W-1:3];
  assign woff    = addr[2:0];
  assign win_hit = (addr < FRM_CFG);
  assign wr_go   = en & we;
  assign rd_go   = en & ~we;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_set
      assign set_en[i] = wr_go & ready & win_hit & (woff == SND_SET) &
                         (ch_idx == CH_IDX_W'(i));
    end
  endgenerate

  assign req_wr  = wr_go & (addr == FRM_REQ);
  assign req_val = wbit0;

  always_comb begin
    rd_d = '0;
    if (win_hit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == CH_IDX_W'(i) && woff == SND_STAT) rd_d = flags[i];
      end
    end else begin
      case (addr)
        FRM_CFG:  rd_d = WORD_W'(NUM_CH);
        FRM_REQ:  rd_d = {31'h0, req_q};
        FRM_RDY:  rd_d = {31'h0, ready};
        FRM_ARCH: rd_d = arch_word(ARCH_MIN);
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_go) rdata <= rd_d;
  end
endmodule

// File: rtl/mbx_rcv_port.sv
module mbx_rcv_port
  import mbx_pkg::*;
#(
  parameter int         NUM_CH   = 4,
  parameter logic [3:0] ARCH_MIN = 4'h1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en,
  input  logic                   we,
  input  waddr_t                 addr,
  input  logic [NUM_CH-1:0][WORD_W-1:0] flags,
  input  logic [NUM_CH-1:0][WORD_W-1:0] masks,
  output logic [NUM_CH-1:0]      clr_en,
  output logic [NUM_CH-1:0]      mset_en,
  output logic [NUM_CH-1:0]      mclr_en,
  output logic                   irq,
  output word_t                  rdata
);
  logic [CH_IDX_W-1:0] ch_idx;
  logic [2:0]          woff;
  logic                win_hit;
  logic                wr_go;
  logic                rd_go;
  word_t               rd_d;
  logic [NUM_CH-1:0][WORD_W-1:0] pend;
  logic [NUM_CH-1:0]   pend_any;

  assign ch_idx  = addr[ADDR_W-1:3];
  assign woff    = addr[2:0];
  assign win_hit = (addr < FRM_CFG);
  assign wr_go   = en & we;
  assign rd_go   = en & ~we;

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic sel;
      assign sel        = wr_go & win_hit & (ch_idx == CH_IDX_W'(i));
      assign clr_en[i]  = sel & (woff == RCV_CLR);
      assign mset_en[i] = sel & (woff == RCV_MSET);
      assign mclr_en[i] = sel & (woff == RCV_MCLR);
      assign pend[i]     = flags[i] & ~masks[i];
      assign pend_any[i] = |pend[i];
    end
  endgenerate

  assign irq = |pend_any;

  always_comb begin
    rd_d = '0;
    if (win_hit) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (ch_idx == CH_IDX_W'(i)) begin
          case (woff)
            RCV_STAT:  rd_d = flags[i];
            RCV_MSTAT: rd_d = pend[i];
            RCV_MASK:  rd_d = masks[i];
            default:   rd_d = '0;
          endcase
        end
      end
    end else begin
      case (addr)
        FRM_CFG:  rd_d = WORD_W'(NUM_CH);
        FRM_ARCH: rd_d = arch_word(ARCH_MIN);
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_go) rdata <= rd_d;
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import mbx_pkg::*;
#(
  parameter int         NUM_CH     = 4,
  parameter logic [3:0] ARCH_MINOR = 4'h1,
  parameter int         READY_LAT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_en,
  input  logic        s_we,
  input  logic [9:0]  s_addr,
  input  logic [31:0] s_wdata,
  output logic [31:0] s_rdata,
  input  logic        r_en,
  input  logic        r_we,
  input  logic [9:0]  r_addr,
  input  logic [31:0] r_wdata,
  output logic [31:0] r_rdata,
  output logic        irq
);
  localparam int CH_OK = (NUM_CH >= 1 && NUM_CH <= CH_LIMIT) ? 1 : 0;

  logic [NUM_CH-1:0][WORD_W-1:0] flag_w;
  logic [NUM_CH-1:0][WORD_W-1:0] mask_w;
  logic [NUM_CH-1:0] set_en;
  logic [NUM_CH-1:0] clr_en;
  logic [NUM_CH-1:0] mset_en;
  logic [NUM_CH-1:0] mclr_en;
  logic acc_req;
  logic acc_ready;
  logic req_wr;
  logic req_val;

  initial begin
    if (CH_OK == 0) $error("NUM_CH out of range");
  end

  mbx_access_hs #(.READY_LAT(READY_LAT)) u_hs (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_val(req_val),
    .req_q(acc_req), .ready(acc_ready)
  );

  mbx_snd_port #(.NUM_CH(NUM_CH), .ARCH_MIN(ARCH_MINOR)) u_snd (
    .clk(clk), .rst_n(rst_n), .en(s_en), .we(s_we), .addr(s_addr),
    .wbit0(s_wdata[0]), .flags(flag_w), .req_q(acc_req), .ready(acc_ready),
    .set_en(set_en), .req_wr(req_wr), .req_val(req_val), .rdata(s_rdata)
  );

  mbx_rcv_port #(.NUM_CH(NUM_CH), .ARCH_MIN(ARCH_MINOR)) u_rcv (
    .clk(clk), .rst_n(rst_n), .en(r_en), .we(r_we), .addr(r_addr),
    .flags(flag_w), .masks(mask_w), .clr_en(clr_en), .mset_en(mset_en),
    .mclr_en(mclr_en), .irq(irq), .rdata(r_rdata)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
      mbx_channel u_ch (
        .clk(clk), .rst_n(rst_n),
        .set_en(set_en[i]), .set_val(s_wdata),
        .clr_en(clr_en[i]), .mset_en(mset_en[i]), .mclr_en(mclr_en[i]),
        .rcv_val(r_wdata),
        .flag_q(flag_w[i]), .mask_q(mask_w[i])
      );
    end
  endgenerate
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int NUM_CH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_en,
  input logic        s_we,
  input logic [31:0] s_rdata,
  input logic        r_en,
  input logic        r_we,
  input logic [31:0] r_rdata,
  input logic        irq,
  input logic        acc_req,
  input logic        acc_ready,
  input logic [NUM_CH-1:0][31:0] flag_w,
  input logic [NUM_CH-1:0][31:0] mask_w
);
  // R3
  locked_sender_no_flag_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_ready && !(r_en && r_we)) |=> $stable(flag_w));

  // R6
  mask_only_by_receiver_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && r_we) |=> $stable(mask_w));

  // R8
  no_flags_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_w == '0) |-> !irq);

  // R9
  ready_rise_after_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_ready) |-> $past(acc_req, 2));

  // R9
  ready_fall_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_ready) |-> !$past(acc_req, 2));

  // R12
  snd_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(s_en && !s_we) |=> $stable(s_rdata));

  // R12
  rcv_rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && !r_we) |=> $stable(r_rdata));
endmodule

bind doorbell_mailbox mbx_checker #(.NUM_CH(NUM_CH)) u_mbx_chk (
  .clk(clk), .rst_n(rst_n), .s_en(s_en), .s_we(s_we), .s_rdata(s_rdata),
  .r_en(r_en), .r_we(r_we), .r_rdata(r_rdata), .irq(irq),
  .acc_req(acc_req), .acc_ready(acc_ready), .flag_w(flag_w), .mask_w(mask_w)
);

// File: tb/tb_doorbell_mailbox.sv
`timescale 1ns/1ps
module tb_doorbell_mailbox;
  localparam int NC = 4;
  localparam logic [3:0] MINOR = 4'h1;
  localparam int WD_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n;
  logic s_en, s_we, r_en, r_we;
  logic [9:0] s_addr, r_addr;
  logic [31:0] s_wdata, r_wdata, s_rdata, r_rdata;
  logic irq;

  int n_chk = 0;
  int n_fail = 0;

  bit [31:0] mf [NC];
  bit [31:0] mm [NC];
  bit m_req, m_d1, m_rdy;
  bit [31:0] exp_s, exp_r;

  always #2.5 clk = ~clk;

  doorbell_mailbox #(.NUM_CH(NC), .ARCH_MINOR(MINOR)) dut (
    .clk(clk), .rst_n(rst_n),
    .s_en(s_en), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata), .s_rdata(s_rdata),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .irq(irq)
  );

  function automatic logic [9:0] cha(input int ch, input int k);
    return 10'(ch * 8 + k);
  endfunction

  function automatic bit [31:0] s_read(input logic [9:0] a);
    if (a < 10'h3E0) begin
      if (int'(a[9:3]) < NC && a[2:0] == 3'd0) return mf[a[9:3]];
      return 32'h0;
    end
    case (a)
      10'h3E0: return 32'(NC);
      10'h3E2: return {31'h0, m_req};
      10'h3E3: return {31'h0, m_rdy};
      10'h3F3: return {24'h0, 4'h1, MINOR};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit [31:0] r_read(input logic [9:0] a);
    if (a < 10'h3E0) begin
      if (int'(a[9:3]) >= NC) return 32'h0;
      case (a[2:0])
        3'd0: return mf[a[9:3]];
        3'd1: return mf[a[9:3]] & ~mm[a[9:3]];
        3'd4: return mm[a[9:3]];
        default: return 32'h0;
      endcase
    end
    case (a)
      10'h3E0: return 32'(NC);
      10'h3F3: return {24'h0, 4'h1, MINOR};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_irq();
    bit any = 1'b0;
    for (int c = 0; c < NC; c++) if ((mf[c] & ~mm[c]) != 0) any = 1'b1;
    return any;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input logic se, swe, input logic [9:0] sa, input logic [31:0] sd,
                            input logic re, rwe, input logic [9:0] ra, input logic [31:0] rd);
    for (int c = 0; c < NC; c++) begin
      bit [31:0] sv, cv, ms, mc;
      sv = 0; cv = 0; ms = 0; mc = 0;
      if (se && swe && m_rdy && sa == cha(c, 3)) sv = sd;
      if (re && rwe && ra == cha(c, 2)) cv = rd;
      if (re && rwe && ra == cha(c, 5)) ms = rd;
      if (re && rwe && ra == cha(c, 6)) mc = rd;
      mf[c] = (mf[c] | sv) & ~cv;
      mm[c] = (mm[c] | ms) & ~mc;
    end
    m_rdy = m_d1;
    m_d1  = m_req;
    if (se && swe && sa == 10'h3E2) m_req = sd[0];
  endtask

  task automatic step(input string tag,
                      input logic se, swe, input logic [9:0] sa, input logic [31:0] sd,
                      input logic re, rwe, input logic [9:0] ra, input logic [31:0] rd);
    @(negedge clk);
    s_en = se; s_we = swe; s_addr = sa; s_wdata = sd;
    r_en = re; r_we = rwe; r_addr = ra; r_wdata = rd;
    @(posedge clk);
    if (se && !swe) exp_s = s_read(sa);
    if (re && !rwe) exp_r = r_read(ra);
    model_edge(se, swe, sa, sd, re, rwe, ra, rd);
    #1;
    chk(tag, "s_rdata", s_rdata, exp_s);
    chk(tag, "r_rdata", r_rdata, exp_r);
    chk(tag, "irq", {31'h0, irq}, {31'h0, exp_irq()});
  endtask

  task automatic sw(input string t, input logic [9:0] a, input logic [31:0] d);
    step(t, 1, 1, a, d, 0, 0, 10'h0, 32'h0);
  endtask
  task automatic srd(input string t, input logic [9:0] a);
    step(t, 1, 0, a, 32'h0, 0, 0, 10'h0, 32'h0);
  endtask
  task automatic rw(input string t, input logic [9:0] a, input logic [31:0] d);
    step(t, 0, 0, 10'h0, 32'h0, 1, 1, a, d);
  endtask
  task automatic rrd(input string t, input logic [9:0] a);
    step(t, 0, 0, 10'h0, 32'h0, 1, 0, a, 32'h0);
  endtask
  task automatic idle(input string t);
    step(t, 0, 0, 10'h0, 32'h0, 0, 0, 10'h0, 32'h0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(WD_CYCLES * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    s_en = 0; s_we = 0; s_addr = 0; s_wdata = 0;
    r_en = 0; r_we = 0; r_addr = 0; r_wdata = 0;
    rst_n = 1'b0;
    for (int c = 0; c < NC; c++) begin mf[c] = 0; mm[c] = '1; end
    m_req = 0; m_d1 = 0; m_rdy = 0; exp_s = 0; exp_r = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state at the ports
    chk("R1", "irq", {31'h0, irq}, 32'h0);
    chk("R1", "s_rdata", s_rdata, 32'h0);
    chk("R1", "r_rdata", r_rdata, 32'h0);
    rrd("R1", cha(0, 4));
    srd("R1", 10'h3E3);
    // R3 set while ready is low is dropped
    sw("R3", cha(0, 3), 32'h0000_00FF);
    srd("R3", cha(0, 0));
    rrd("R3", cha(0, 0));
    // R9 handshake timing
    sw("R9", 10'h3E2, 32'h1);
    srd("R9", 10'h3E3);
    srd("R9", 10'h3E3);
    srd("R9", 10'h3E3);
    srd("R9", 10'h3E2);
    // R2 set accumulates by OR
    sw("R2", cha(0, 3), 32'h0000_00F0);
    sw("R2", cha(0, 3), 32'h0000_000F);
    srd("R2", cha(0, 0));
    // R6 / R7 / R8 masking and interrupt
    rw("R8", cha(0, 6), 32'hFFFF_FFFF);
    rrd("R6", cha(0, 4));
    rw("R6", cha(0, 5), 32'h0000_000F);
    rrd("R6", cha(0, 4));
    rrd("R7", cha(0, 1));
    rw("R8", cha(0, 5), 32'h0000_00F0);
    rrd("R7", cha(0, 1));
    // R5 same-cycle set and clear on channel 1
    rw("R5", cha(1, 6), 32'hFFFF_FFFF);
    step("R5", 1, 1, cha(1, 3), 32'h0000_0003, 1, 1, cha(1, 2), 32'h0000_0001);
    rrd("R5", cha(1, 0));
    srd("R5", cha(1, 0));
    // R4 clear all ones
    rw("R4", cha(1, 2), 32'hFFFF_FFFF);
    rrd("R4", cha(1, 0));
    rw("R4", cha(0, 2), 32'h0000_0030);
    rrd("R4", cha(0, 0));
    // R10 configuration and identifier
    srd("R10", 10'h3E0);
    rrd("R10", 10'h3E0);
    srd("R10", 10'h3F3);
    rrd("R10", 10'h3F3);
    // R11 reserved space
    sw("R11", cha(NC, 3), 32'hA5A5_A5A5);
    srd("R11", cha(NC, 0));
    rw("R11", cha(NC, 6), 32'hFFFF_FFFF);
    rrd("R11", cha(NC, 4));
    sw("R11", 10'h3E1, 32'hFFFF_FFFF);
    srd("R11", 10'h3E1);
    rw("R11", cha(2, 7), 32'hFFFF_FFFF);
    rrd("R11", cha(2, 7));
    rrd("R11", cha(2, 4));
    srd("R11", cha(1, 1));
    // R12 hold without reads
    idle("R12");
    idle("R12");
    // random mix on both buses
    for (int n = 0; n < 2500; n++) begin
      logic se, swe, re, rwe;
      logic [9:0] sa, ra;
      logic [31:0] sd, rd;
      int so, ro;
      so = int'($urandom % 8); ro = int'($urandom % 8);
      se = 0; swe = 0; sa = 0; sd = $urandom & $urandom;
      re = 0; rwe = 0; ra = 0; rd = $urandom & $urandom;
      case (so)
        0, 1, 2: begin se = 1; swe = 1; sa = cha(int'($urandom % (NC + 1)), 3); end
        3: begin se = 1; sa = cha(int'($urandom % (NC + 1)), int'($urandom % 8)); end
        4: begin se = 1; sa = 10'h3E0 + 10'($urandom % 4); end
        5: if ($urandom % 8 == 0) begin se = 1; swe = 1; sa = 10'h3E2; sd = 32'($urandom % 4 != 0); end
        default: ;
      endcase
      case (ro)
        0: begin re = 1; rwe = 1; ra = cha(int'($urandom % (NC + 1)), 2); end
        1: begin re = 1; rwe = 1; ra = cha(int'($urandom % (NC + 1)), 5); end
        2: begin re = 1; rwe = 1; ra = cha(int'($urandom % (NC + 1)), 6); end
        3, 4, 5: begin re = 1; ra = cha(int'($urandom % (NC + 1)), int'($urandom % 8)); end
        6: begin re = 1; ra = ($urandom % 2 == 0) ? 10'h3E0 : 10'h3F3; end
        default: ;
      endcase
      step("RND", se, swe, sa, sd, re, rwe, ra, rd);
    end
    // R9 release
    sw("R9", 10'h3E2, 32'h0);
    srd("R9", 10'h3E3);
    srd("R9", 10'h3E3);
    srd("R9", 10'h3E3);
    sw("R3", cha(2, 3), 32'hFFFF_0000);
    rrd("R3", cha(2, 0));
    summary();
  end
endmodule